// File: doc/BRIEF.md
# Two-Street Traffic Light Controller with Parade Hold

This block drives the lamps of a crossing between two streets, called here the main street and the side street. It is factored into two small state machines. A phase machine steps through four phases: main green, main yellow, side green, side yellow. A mode machine holds a parade flag. Sensors on each street tell the phase machine whether traffic is waiting or passing. Two one-cycle command pulses put the crossing into parade mode and take it out again. While the parade flag is set, the side street keeps its green no matter what its sensor reports.

Each phase lasts at least one clock, and both yellow phases last exactly one. No real-time yellow timing is modelled. Reset is synchronous and active high. All state changes happen on the rising clock edge. The lamp outputs depend only on the current phase, so they are registered-state decodes with no input-to-output path.

Top module: `traffic_ctrl`

## Requirements
- R1: When `rst` is high at a rising edge, the next phase is main green and the parade flag is 0. In main green, `lamp_main` is green (2'b00) and `lamp_side` is red (2'b10).
- R2: In main green, the controller stays there while `sense_main` is 1. It moves to main yellow at the edge where `sense_main` is 0.
- R3: In main yellow, `lamp_main` is yellow (2'b01) and `lamp_side` is red (2'b10). This phase lasts exactly one cycle and is followed by side green.
- R4: In side green, `lamp_main` is red (2'b10) and `lamp_side` is green (2'b00). The controller stays in side green while the parade flag or `sense_side` is 1. It moves to side yellow only when both are 0 at the edge.
- R5: In side yellow, `lamp_main` is red (2'b10) and `lamp_side` is yellow (2'b01). This phase lasts exactly one cycle and is followed by main green.
- R6: A pulse on `parade_start` sets the parade flag at the next edge, and a pulse on `parade_end` clears it. With neither pulse, the flag holds its value.
- R7: When `parade_start` and `parade_end` are both high in the same cycle, the leave command wins: after the edge the parade flag is 0.
- R8: In every cycle out of reset, at least one of `lamp_main` and `lamp_side` shows red (2'b10). The two streets never show green or yellow at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sense_main | input | 1 | Traffic present on the main street |
| sense_side | input | 1 | Traffic present on the side street |
| parade_start | input | 1 | One-cycle command that enters parade mode |
| parade_end | input | 1 | One-cycle command that leaves parade mode; wins over `parade_start` |
| lamp_main | output | 2 | Main street lamp: 00 green, 01 yellow, 10 red |
| lamp_side | output | 2 | Side street lamp: 00 green, 01 yellow, 10 red |
| parade_active | output | 1 | Current parade flag |

## Verification
The bench targets the parade hold. It drops the side sensor while the flag is set and checks that the side street stays green. A design that reads only the sensor would let the side street turn yellow in the middle of a parade.

It also asserts both commands in the same cycle, from either flag value. A design that gives the enter command priority would leave the flag stuck at 1.

It holds the main sensor high across several cycles to catch an early exit from main green. It counts the yellow phases to catch one that is skipped or stretched.

Every cycle is compared against a behavioural model, together with a check that one street always shows red. An encoding swap or a wrong transition shows up as a mismatch on the lamp codes.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int LAMP_W = 2;
  typedef logic [LAMP_W-1:0] lamp_t;
  localparam lamp_t LAMP_GO   = 2'b00;
  localparam lamp_t LAMP_WARN = 2'b01;
  localparam lamp_t LAMP_STOP = 2'b10;

  typedef enum logic [1:0] {
    PH_MAIN_GO   = 2'd0,
    PH_MAIN_WARN = 2'd1,
    PH_SIDE_GO   = 2'd2,
    PH_SIDE_WARN = 2'd3
  } phase_t;

  // Lamp shown to the main street in a given phase
  function automatic lamp_t main_lamp(input phase_t ph);
    case (ph)
      PH_MAIN_GO:   main_lamp = LAMP_GO;
      PH_MAIN_WARN: main_lamp = LAMP_WARN;
      default:      main_lamp = LAMP_STOP;
    endcase
  endfunction

  // Lamp shown to the side street in a given phase
  function automatic lamp_t side_lamp(input phase_t ph);
    case (ph)
      PH_SIDE_GO:   side_lamp = LAMP_GO;
      PH_SIDE_WARN: side_lamp = LAMP_WARN;
      default:      side_lamp = LAMP_STOP;
    endcase
  endfunction
endpackage

// File: rtl/tlc_mode_fsm.sv
module tlc_mode_fsm (
  input  logic clk,
  input  logic rst,
  input  logic enter_cmd,
  input  logic leave_cmd,
  output logic parade
);
  // Named events for the checks below
  logic enter_evt;
  logic leave_evt;
  assign leave_evt = leave_cmd;
  assign enter_evt = enter_cmd & ~leave_cmd;

  always_ff @(posedge clk) begin
    if (rst)            parade <= 1'b0;
    else if (leave_evt) parade <= 1'b0;
    else if (enter_evt) parade <= 1'b1;
  end

  a_r6_enter_sets: assert property (@(posedge clk) disable iff (rst)
    (enter_cmd && !leave_cmd) |=> parade);
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!enter_cmd && !leave_cmd) |=> (parade == $past(parade)));
  a_r7_leave_wins: assert property (@(posedge clk) disable iff (rst)
    leave_cmd |=> !parade);
endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   main_busy,
  input  logic   side_busy,
  input  logic   parade,
  output phase_t phase
);
  phase_t phase_nx;
  logic   side_keep;   // side green must be held this cycle
  assign side_keep = parade | side_busy;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_MAIN_GO:   if (!main_busy) phase_nx = PH_MAIN_WARN;
      PH_MAIN_WARN: phase_nx = PH_SIDE_GO;
      PH_SIDE_GO:   if (!side_keep) phase_nx = PH_SIDE_WARN;
      PH_SIDE_WARN: phase_nx = PH_MAIN_GO;
      default:      phase_nx = PH_MAIN_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_MAIN_GO;
    else     phase <= phase_nx;
  end

  a_r2_main_holds: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MAIN_GO && main_busy) |=> (phase == PH_MAIN_GO));
  a_r3_main_warn_once: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MAIN_WARN) |=> (phase == PH_SIDE_GO));
  a_r4_parade_holds: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SIDE_GO && parade) |=> (phase == PH_SIDE_GO));
  a_r5_side_warn_once: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SIDE_WARN) |=> (phase == PH_MAIN_GO));
endmodule

// File: rtl/traffic_ctrl.sv
module traffic_ctrl
  import tlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sense_main,
  input  logic              sense_side,
  input  logic              parade_start,
  input  logic              parade_end,
  output logic [LAMP_W-1:0] lamp_main,
  output logic [LAMP_W-1:0] lamp_side,
  output logic              parade_active
);
  phase_t phase;
  logic   parade;

  tlc_mode_fsm u_mode (
    .clk       (clk),
    .rst       (rst),
    .enter_cmd (parade_start),
    .leave_cmd (parade_end),
    .parade    (parade)
  );

  tlc_phase_fsm u_phase (
    .clk       (clk),
    .rst       (rst),
    .main_busy (sense_main),
    .side_busy (sense_side),
    .parade    (parade),
    .phase     (phase)
  );

  assign lamp_main     = main_lamp(phase);
  assign lamp_side     = side_lamp(phase);
  assign parade_active = parade;

  a_r8_one_street_red: assert property (@(posedge clk) disable iff (rst)
    (lamp_main == LAMP_STOP) || (lamp_side == LAMP_STOP));
endmodule

// File: tb/traffic_ctrl_test.sv
module traffic_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, sm, ss, ps, pe;
  logic [1:0] lm, ls;
  logic pa;
  int checks = 0;
  int fails  = 0;

  // Behavioural model: 0 main green, 1 main yellow, 2 side green, 3 side yellow
  int m_ph;
  int m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  traffic_ctrl uut (
    .clk(clk), .rst(rst), .sense_main(sm), .sense_side(ss),
    .parade_start(ps), .parade_end(pe),
    .lamp_main(lm), .lamp_side(ls), .parade_active(pa)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected codes per model phase: 00 green, 01 yellow, 10 red
  function automatic int exp_main(input int p);
    return (p == 0) ? 0 : (p == 1) ? 1 : 2;
  endfunction
  function automatic int exp_side(input int p);
    return (p == 2) ? 0 : (p == 3) ? 1 : 2;
  endfunction

  // One clock: model advances with the inputs present at the edge,
  // outputs compared at the following falling edge.
  task automatic step();
    string tag_ph;
    string tag_md;
    int old_ph;
    old_ph = m_ph;
    @(posedge clk);
    if (rst) begin
      m_ph = 0; m_flag = 0;
      tag_ph = "R1"; tag_md = "R1";
    end else begin
      case (old_ph)
        0: begin tag_ph = "R2"; if (sm == 1'b0) m_ph = 1; end
        1: begin tag_ph = "R3"; m_ph = 2; end
        2: begin tag_ph = "R4"; if (m_flag == 0 && ss == 1'b0) m_ph = 3; end
        default: begin tag_ph = "R5"; m_ph = 0; end
      endcase
      tag_md = (ps && pe) ? "R7" : "R6";
      if (pe) m_flag = 0;
      else if (ps) m_flag = 1;
    end
    @(negedge clk);
    check({tag_ph, " main lamp"}, int'(lm), exp_main(m_ph));
    check({tag_ph, " side lamp"}, int'(ls), exp_side(m_ph));
    check({tag_md, " parade flag"}, int'(pa), m_flag);
    if (!rst) check("R8 one street red", int'(lm == 2'b10 || ls == 2'b10), 1);
  endtask

  task automatic drive(input logic a, input logic b, input logic s, input logic e);
    sm = a; ss = b; ps = s; pe = e;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    m_ph = 0; m_flag = 0;
    rst = 1'b1; sm = 1'b1; ss = 1'b1; ps = 1'b1; pe = 1'b0;
    @(negedge clk);
    step(); step();                       // R1 reset state, even with commands high
    rst = 1'b0;
    repeat (3) drive(1, 0, 0, 0);         // R2 main holds while busy
    drive(0, 0, 0, 0);                    // R2 -> main yellow
    drive(0, 1, 0, 0);                    // R3 -> side green
    repeat (3) drive(0, 1, 0, 0);         // R4 sensor holds side green
    drive(0, 0, 0, 0);                    // R4 -> side yellow
    drive(1, 0, 0, 0);                    // R5 -> main green
    drive(1, 0, 1, 0);                    // R6 enter parade
    drive(1, 0, 0, 0);                    // R6 flag holds
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);                    // now side green
    repeat (5) drive(0, 0, 0, 0);         // R4 parade holds side green
    drive(0, 0, 1, 1);                    // R7 both commands: leave wins
    drive(0, 0, 0, 0);                    // R4 leaves side green
    drive(0, 0, 1, 1);                    // R7 from flag 0
    drive(0, 0, 1, 0);                    // R6 enter
    drive(0, 0, 0, 1);                    // R6 leave alone
    lfsr = 8'hA5;
    for (int i = 0; i < 150; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(lfsr[0], lfsr[1], lfsr[2] & lfsr[5], lfsr[3] & lfsr[6]);
    end
    rst = 1'b1; drive(0, 0, 0, 0);        // R1 reset mid-run
    rst = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule